// File: doc/BRIEF.md
# Periodic Ready-Driven Stream Sampler

This block takes readings from an upstream stream whose data word may change on every clock while its valid is held high. The sampler sets the sampling rate itself: it raises its ready once per programmed interval, and the word present on the cycle where ready and valid are both high becomes one sample. Every other word is dropped. Because the sampler paces the transfers with ready, and the source does not pace them with valid, the spacing between samples stays fixed.

Captured samples go into a two-entry output stage and leave on a ready/valid source port toward a downstream consumer. When a sample falls due while both output entries are still waiting for the consumer, the sampler skips that slot. It keeps ready low and increments a saturating overrun counter, so a stored sample is never overwritten. Reset is synchronous and active low.

Top module: `stream_sampler`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `in_ready` and `out_valid` are low and `overrun_cnt` is zero.
- R2: A sampling slot opens on the second cycle after reset is released and then once every `interval` cycles. An `interval` of 0 counts as 1. On a slot cycle with `in_valid` high and output space free, `in_ready` is high for that cycle only.
- R3: With `interval` = 1, `in_valid` held high and `out_ready` held high, `in_ready` stays high on every cycle once the first slot has opened.
- R4: The sample taken is exactly the `in_data` value on the cycle where `in_valid` and `in_ready` are both high. Samples leave on `out_data` in capture order.
- R5: If `in_valid` is low when a slot opens, `in_ready` stays high from that slot onward until `in_valid` goes high. The capture then happens on that cycle.
- R6: Within any cycle, `in_ready` does not depend on the value of `in_valid`.
- R7: Once `out_valid` is high it stays high, with `out_data` unchanged, until a cycle where `out_ready` is also high.
- R8: The output stage holds two samples. If a slot opens while both entries are occupied, `in_ready` stays low for that slot and `overrun_cnt` rises by one, saturating at its all-ones value.
- R9: A new `interval` value is read only when a slot opens, so it first changes the spacing after the slot that is currently counting.
- R10: A slot that opens while an earlier slot is still waiting for `in_valid` merges with it. Ready stays high and `overrun_cnt` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| interval | input | INTV_W | Sampling period in cycles (0 treated as 1) |
| in_valid | input | 1 | Upstream data valid |
| in_data | input | DATA_W | Upstream data word |
| in_ready | output | 1 | Sampling pulse toward upstream |
| out_valid | output | 1 | A captured sample is presented |
| out_data | output | DATA_W | Oldest captured sample |
| out_ready | input | 1 | Downstream accepts the sample |
| overrun_cnt | output | OVR_W | Saturating count of skipped slots |

## Verification
The bench targets four corner cases.

The first is a slot that opens while `in_valid` is low. A design that dropped ready after one cycle would lose that sample for good.

The second is a slot that opens while both output entries are full. A design that overwrote a stored entry would put out the wrong data, and one that sampled anyway would break the hold rule on the output.

The third is an interval of 1 with steady downstream flow. A single-register output stage would give only every other sample here, and the bench catches this because it expects ready to stay high.

The fourth is an interval change in the middle of a count. A design that reloaded at once would shift the next slot early, and the bench's cycle-level reference model flags that shift.

// File: rtl/sampler_pkg.sv
// Shared types for the periodic stream sampler.
package sampler_pkg;

    // Occupancy of the two-entry output stage.
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_ONE   = 2'd1,
        OCC_TWO   = 2'd2
    } occ_t;

endpackage

// File: rtl/smp_interval_timer.sv
// Interval timer: raises slot_open on one cycle per programmed interval.
// Assumes: interval of 0 counts as 1; the interval is read only at reload.
// The first slot opens on the second cycle after reset is released.
module smp_interval_timer #(
    parameter int INTV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INTV_W-1:0] interval,
    output logic              slot_open
);
    localparam logic [INTV_W-1:0] ONE = {{(INTV_W-1){1'b0}}, 1'b1};

    logic              armed_q;
    logic [INTV_W-1:0] left_q;
    logic [INTV_W-1:0] reload;

    assign slot_open = armed_q && (left_q == '0);

    // Reload value: cycles between slots minus one.
    always_comb begin
        reload = (interval <= ONE) ? '0 : interval - ONE;
    end

    // Down-counter; it reloads on every slot and samples the interval then.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            left_q  <= '0;
        end else begin
            armed_q <= 1'b1;
            if (slot_open)
                left_q <= reload;
            else if (armed_q)
                left_q <= left_q - ONE;
        end
    end

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && left_q != '0) |=> (left_q == $past(left_q) - ONE)); // R2

endmodule

// File: rtl/smp_capture_ctl.sv
// Capture control: turns slots into ready, tracks slots that wait for valid,
// and counts slots skipped because the output stage is full.
// Assumes: buf_full is registered state; in_ready is never a function of in_valid.
module smp_capture_ctl #(
    parameter int OVR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_open,
    input  logic             buf_full,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             capture,
    output logic [OVR_W-1:0] overrun_cnt
);
    localparam logic [OVR_W-1:0] OVR_ONE = {{(OVR_W-1){1'b0}}, 1'b1};

    logic             wait_q;
    logic [OVR_W-1:0] ovr_q;

    // Ready comes from the timer and registered flags only.
    assign in_ready    = (slot_open || wait_q) && !buf_full;
    assign capture     = in_ready && in_valid;
    assign overrun_cnt = ovr_q;

    // Pending slot: stays set until a capture consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wait_q <= 1'b0;
        else
            wait_q <= ((slot_open && !buf_full) || wait_q) && !capture;
    end

    // Saturating count of slots that found the output stage full.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr_q <= '0;
        else if (slot_open && buf_full && (ovr_q != '1))
            ovr_q <= ovr_q + OVR_ONE;
    end

    AST_WAIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !wait_q); // R5

    AST_OVR_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ovr_q >= $past(ovr_q))); // R8

endmodule

// File: rtl/smp_out_buf.sv
// Two-entry output stage presenting samples on a ready/valid source port.
// Assumes: the writer never pushes while full is high.
// Head entry drives out_data; the spare entry absorbs one extra sample.
module smp_out_buf
    import sampler_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    output logic              full,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready
);
    occ_t              occ_q;
    logic [DATA_W-1:0] head_q;
    logic [DATA_W-1:0] spare_q;
    logic              pop;

    assign full      = (occ_q == OCC_TWO);
    assign out_valid = (occ_q != OCC_EMPTY);
    assign out_data  = head_q;
    assign pop       = out_valid && out_ready;

    // Occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n)
            occ_q <= OCC_EMPTY;
        else if (push && !pop)
            occ_q <= (occ_q == OCC_EMPTY) ? OCC_ONE : OCC_TWO;
        else if (pop && !push)
            occ_q <= (occ_q == OCC_TWO) ? OCC_ONE : OCC_EMPTY;
    end

    // Data movement between entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            spare_q <= '0;
        end else begin
            unique case (occ_q)
                OCC_EMPTY: if (push) head_q <= din;
                OCC_ONE: begin
                    if (push && pop) head_q  <= din;
                    else if (push)   spare_q <= din;
                end
                OCC_TWO: if (pop) head_q <= spare_q;
                default: ;
            endcase
        end
    end

    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push); // R8

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

endmodule

// File: rtl/stream_sampler.sv
// Periodic ready-driven stream sampler (top).
// The upstream source holds valid and changes data freely; this block pulses
// ready once per interval, captures on the completing cycle and forwards the
// sample downstream. Assumes a synchronous active-low reset.
module stream_sampler #(
    parameter int DATA_W = 16,
    parameter int INTV_W = 8,
    parameter int OVR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INTV_W-1:0] interval,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    output logic [OVR_W-1:0]  overrun_cnt
);
    logic slot_open;
    logic buf_full;
    logic capture;

    smp_interval_timer #(.INTV_W(INTV_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .interval  (interval),
        .slot_open (slot_open)
    );

    smp_capture_ctl #(.OVR_W(OVR_W)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_open   (slot_open),
        .buf_full    (buf_full),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .capture     (capture),
        .overrun_cnt (overrun_cnt)
    );

    smp_out_buf #(.DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (capture),
        .din       (in_data),
        .full      (buf_full),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready)
    );

    AST_CAPTURE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> out_valid); // R4

endmodule

// File: tb/stream_sampler_tb.sv
module stream_sampler_tb;
    localparam int DW = 16;
    localparam int IW = 8;
    localparam int OW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] interval = '0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_ready;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_ready = 1'b0;
    logic [OW-1:0] overrun_cnt;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Reference model state, derived from the requirements.
    bit            m_run, m_pend;
    int            m_left, m_n, m_ovr;
    logic [DW-1:0] m_q0, m_q1;

    stream_sampler #(.DATA_W(DW), .INTV_W(IW), .OVR_W(OW)) u_dut (
        .clk(clk), .rst_n(rst_n), .interval(interval),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .overrun_cnt(overrun_cnt)
    );

    always #4 clk = ~clk; // 125 MHz

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit exp_ready();
        return ((m_run && m_left == 0) || m_pend) && (m_n < 2);
    endfunction

    task automatic model_reset();
        m_run = 0; m_pend = 0; m_left = 0; m_n = 0; m_ovr = 0; m_q0 = '0; m_q1 = '0;
    endtask

    // One cycle of the reference model, from the requirements.
    task automatic model_step(input bit v, input logic [DW-1:0] d, input bit ordy, input int ivl);
        bit tick, rdy, hs, pop;
        tick = m_run && (m_left == 0);
        rdy  = exp_ready();
        hs   = v && rdy;
        pop  = (m_n > 0) && ordy;
        if (tick && m_n == 2 && m_ovr < (1 << OW) - 1) m_ovr++;
        m_pend = ((tick && m_n < 2) || m_pend) && !hs;
        if (pop) begin m_q0 = m_q1; m_n--; end
        if (hs) begin
            if (m_n == 0) m_q0 = d; else m_q1 = d;
            m_n++;
        end
        if (!m_run) m_run = 1;
        else if (tick) m_left = (ivl <= 1) ? 0 : ivl - 1;
        else m_left--;
    endtask

    task automatic check_outputs(input string ready_tag);
        check(in_ready === exp_ready(), ready_tag, "in_ready", in_ready, exp_ready());
        check(out_valid === (m_n > 0), "R7", "out_valid", out_valid, m_n > 0);
        if (m_n > 0) check(out_data === m_q0, "R4", "out_data", out_data, m_q0);
        check(overrun_cnt === OW'(m_ovr), "R8", "overrun_cnt", overrun_cnt, m_ovr);
    endtask

    // Drive one cycle at the falling edge and compare after the next rising edge.
    task automatic run_cycle(input bit v, input logic [DW-1:0] d, input bit ordy,
                             input int ivl, input string tag);
        logic r_a;
        interval  = IW'(ivl);
        in_data   = d;
        out_ready = ordy;
        in_valid  = ~v;
        #1 r_a = in_ready;
        in_valid = v;
        #1 check(in_ready === r_a, "R6", "in_ready vs in_valid", in_ready, r_a);
        model_step(v, d, ordy, ivl);
        @(posedge clk);
        @(negedge clk);
        check_outputs(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int hs_count;
        void'($urandom(32'd2024));
        model_reset();
        // R1: reset state
        repeat (3) @(negedge clk);
        check(in_ready === 1'b0, "R1", "in_ready in reset", in_ready, 0);
        check(out_valid === 1'b0, "R1", "out_valid in reset", out_valid, 0);
        check(overrun_cnt === '0, "R1", "overrun in reset", overrun_cnt, 0);
        rst_n = 1'b1;
        model_reset();
        #1 check(in_ready === 1'b0, "R1", "in_ready after release", in_ready, 0);

        // R2: interval 3, steady flow; one capture every three cycles
        hs_count = 0;
        for (int i = 0; i < 30; i++) begin
            if (exp_ready()) hs_count++;
            run_cycle(1, DW'($urandom), 1, 3, "R2");
        end
        check(hs_count == 10, "R2", "slots in 30 cycles", hs_count, 10);

        // R2: interval 0 behaves as 1
        for (int i = 0; i < 8; i++) run_cycle(1, DW'($urandom), 1, 0, "R2");

        // R3: interval 1 keeps ready high
        for (int i = 0; i < 20; i++) begin
            run_cycle(1, DW'($urandom), 1, 1, "R3");
            check(in_ready === 1'b1, "R3", "ready continuous", in_ready, 1);
        end

        // R5 and R10: valid low across several slots, then returns
        for (int i = 0; i < 9; i++) run_cycle(0, DW'($urandom), 1, 2, "R10");
        check(in_ready === 1'b1, "R5", "ready waits for valid", in_ready, 1);
        check(overrun_cnt === OW'(m_ovr), "R10", "no overrun while waiting", overrun_cnt, m_ovr);
        run_cycle(1, 16'hA5C3, 1, 2, "R5");
        check(out_data === 16'hA5C3, "R5", "late capture data", out_data, 16'hA5C3);

        // R7 and R8: downstream stalled, buffer fills, slots overrun
        for (int i = 0; i < 16; i++) run_cycle(1, DW'($urandom), 0, 2, "R8");
        check(overrun_cnt === OW'(m_ovr) && m_ovr > 0, "R8", "overrun counted", overrun_cnt, m_ovr);
        for (int i = 0; i < 6; i++) run_cycle(1, DW'($urandom), 1, 2, "R7");

        // R9: interval change in the middle of a count
        for (int i = 0; i < 7; i++) run_cycle(1, DW'($urandom), 1, 6, "R9");
        for (int i = 0; i < 14; i++) run_cycle(1, DW'($urandom), 1, 2, "R9");

        // Random mix (R2, R4, R7, R8)
        begin
            int ivl = 3;
            for (int i = 0; i < 3000; i++) begin
                if (($urandom % 50) == 0) ivl = $urandom % 6;
                run_cycle(($urandom % 4) != 0, DW'($urandom), ($urandom % 3) != 0, ivl, "R2");
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule